// File: doc/BRIEF.md
# Sector Erase Scheduler with Suspend

This controller collects a group of flash sectors to erase, then walks through them one by one and drives a separate erase engine. A sector-add command opens a timed acceptance window measured in microsecond ticks. Each further sector-add puts its sector into a selection mask and restarts the window. When the window runs out, the controller drops the protected sectors from the selection. It then runs a preprogram step followed by an erase step for each remaining sector, starting at the lowest index.

A chip-erase command skips the window and selects every unprotected sector. An erase suspend pauses a sector erase until a resume arrives. A suspend during chip erase is ignored. A hardware reset strobe aborts any activity at once.

The status logic reads four flags: busy, window_open, erasing and suspended. The bus decoder supplies one-cycle command strobes. The engine acknowledges each request with a one-cycle done pulse.

Top module: `sector_erase_sched`

## Requirements
- R1: After reset, busy, window_open, erasing and suspended are all low, and neither engine request is asserted.
- R2: In idle, a sector-add whose index is below NUM_SECT opens the window (window_open high, busy high). Each further sector-add during the window ORs the sector into the selection and restarts the count. The window closes on the WIN_US-th us_tick after the last add. Sector index i is a binary value and selects bit i of the selection.
- R3: During the window, a chip-erase, resume or other-command strobe discards the selection and returns to idle. No engine request follows.
- R4: A suspend during the window closes it at once and raises suspended, with busy and erasing low and no engine request. A later resume starts the erase of the held selection.
- R5: Selected sectors are processed in rising index order. Each sector gets an eng_pre_req step and then an eng_ers_req step. Each step ends on eng_done, and eng_sect holds the sector index during the step.
- R6: Any sector whose prot_mask bit is 1 at the start of the erase is dropped from the selection and gets no engine request. Bit i of prot_mask protects sector i.
- R7: If every selected sector is protected, erasing and busy stay high for ALLPROT_US us_ticks with no engine request, and then the block returns to idle.
- R8: A suspend during a sector erase raises suspended when the current step completes or when SUSP_US us_ticks have passed, whichever comes first. No request is issued while suspended. Resume continues from the interrupted step, and an aborted step is repeated.
- R9: In idle, chip-erase starts the erase at once with all unprotected sectors and no window. During chip erase, suspend and resume are ignored.
- R10: While erasing, sector-add and other-command strobes have no effect on the sector sequence. A resume in idle has no effect.
- R11: A hw_reset strobe returns the block to idle in the next cycle from any state, drops all requests and clears the selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hw_reset | input | 1 | Hardware reset command strobe, aborts everything |
| cmd_sect_add | input | 1 | Sector erase command strobe |
| cmd_chip_erase | input | 1 | Chip erase command strobe |
| cmd_suspend | input | 1 | Erase suspend strobe |
| cmd_resume | input | 1 | Erase resume strobe |
| cmd_other | input | 1 | Any other decoded command |
| sect_idx | input | IW | Sector index for cmd_sect_add |
| prot_mask | input | NUM_SECT | Per-sector protection, 1 = protected |
| us_tick | input | 1 | One-microsecond tick |
| eng_done | input | 1 | Engine step completion pulse |
| eng_pre_req | output | 1 | Preprogram request for eng_sect |
| eng_ers_req | output | 1 | Erase request for eng_sect |
| eng_sect | output | IW | Sector under work |
| busy | output | 1 | Window, erase or all-protected wait in progress |
| window_open | output | 1 | Acceptance window running |
| erasing | output | 1 | Erase phase (including all-protected wait) |
| suspended | output | 1 | Erase suspended |

## Verification
The bench checks the window length exactly one tick before and at its expiry, and again after a restart. A design that did not restart the window, or was off by one tick, would start erasing early. A scoreboard lists the expected preprogram and erase steps per sector. Any wrong order, a request for a protected sector, or a step repeated or dropped around a suspend shows up as a miscompare. Suspend is exercised three ways:
- during the window, where a design that began erasing would issue unexpected requests;
- at a step boundary;
- through the SUSP_US timeout, where a late or early suspended flag is caught to the tick.

Two further tests cover chip erase and reset. During chip erase, a suspend that was not ignored would raise the suspended flag. A hardware reset that did not clear the selection would let requests appear afterwards.

// File: rtl/sched_pkg.sv
package sched_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WINDOW,
        ST_SUSP_WIN,
        ST_RUN,
        ST_SUSP_RUN,
        ST_ALLPROT
    } sched_st_e;

    typedef enum logic {
        STEP_PRE,
        STEP_ERASE
    } step_e;

    typedef struct packed {
        sched_st_e st;
        step_e     step;
        logic      chip;
        logic      pend;
    } ctl_t;

    localparam ctl_t CTL_RESET = '{st: ST_IDLE, step: STEP_PRE, chip: 1'b0, pend: 1'b0};

    function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/sect_picker.sv
module sect_picker #(
    parameter int NUM_SECT = 11,
    parameter int IW = 4
) (
    input  logic [NUM_SECT-1:0] mask,
    output logic [IW-1:0]       idx,
    output logic                valid
);
    always_comb begin
        idx   = '0;
        valid = |mask;
        for (int i = NUM_SECT - 1; i >= 0; i--) begin
            if (mask[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/tick_timer.sv
module tick_timer #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         tick,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst || clr) cnt <= '0;
        else if (tick && cnt != '1) cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/sector_erase_sched.sv
module sector_erase_sched
    import sched_pkg::*;
#(
    parameter int NUM_SECT   = 11,
    parameter int IW         = 4,
    parameter int WIN_US     = 50,
    parameter int SUSP_US    = 20,
    parameter int ALLPROT_US = 100
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                hw_reset,
    input  logic                cmd_sect_add,
    input  logic                cmd_chip_erase,
    input  logic                cmd_suspend,
    input  logic                cmd_resume,
    input  logic                cmd_other,
    input  logic [IW-1:0]       sect_idx,
    input  logic [NUM_SECT-1:0] prot_mask,
    input  logic                us_tick,
    input  logic                eng_done,
    output logic                eng_pre_req,
    output logic                eng_ers_req,
    output logic [IW-1:0]       eng_sect,
    output logic                busy,
    output logic                window_open,
    output logic                erasing,
    output logic                suspended
);
    localparam int TW = $clog2(max3(WIN_US, SUSP_US, ALLPROT_US) + 1);

    ctl_t                ctl, ctl_n;
    logic [NUM_SECT-1:0] sel, sel_n;
    logic                restart;
    logic [TW-1:0]       cnt;
    logic [IW-1:0]       pick_idx;
    logic                pick_valid;
    logic                idx_ok;
    logic [NUM_SECT-1:0] add_bit, cur_bit, launch_src, eff;
    logic                exp_win, exp_sus, exp_all;

    tick_timer #(.W(TW)) timer_i (
        .clk(clk), .rst(rst), .clr(restart), .tick(us_tick), .cnt(cnt)
    );

    sect_picker #(.NUM_SECT(NUM_SECT), .IW(IW)) picker_i (
        .mask(sel), .idx(pick_idx), .valid(pick_valid)
    );

    assign idx_ok  = int'(sect_idx) < NUM_SECT;
    assign add_bit = idx_ok ? (NUM_SECT'(1) << sect_idx) : '0;
    assign cur_bit = NUM_SECT'(1) << pick_idx;
    assign exp_win = us_tick && (cnt == TW'(WIN_US - 1));
    assign exp_sus = us_tick && (cnt == TW'(SUSP_US - 1));
    assign exp_all = us_tick && (cnt == TW'(ALLPROT_US - 1));

    // selection that an erase start would use: all sectors for chip erase
    assign launch_src = (ctl.st == ST_IDLE) ? '1 : sel;
    assign eff        = launch_src & ~prot_mask;

    always_comb begin
        ctl_n   = ctl;
        sel_n   = sel;
        restart = 1'b0;
        unique case (ctl.st)
            ST_IDLE: begin
                if (cmd_sect_add && idx_ok) begin
                    ctl_n.st = ST_WINDOW;
                    sel_n    = add_bit;
                    restart  = 1'b1;
                end else if (cmd_chip_erase) begin
                    ctl_n.chip = 1'b1;
                    ctl_n.step = STEP_PRE;
                    if (eff == '0) begin
                        ctl_n.st = ST_ALLPROT;
                        sel_n    = '0;
                        restart  = 1'b1;
                    end else begin
                        ctl_n.st = ST_RUN;
                        sel_n    = eff;
                    end
                end
            end
            ST_WINDOW: begin
                if (cmd_other || cmd_chip_erase || cmd_resume) begin
                    ctl_n.st = ST_IDLE;
                    sel_n    = '0;
                end else if (cmd_suspend) begin
                    ctl_n.st = ST_SUSP_WIN;
                end else if (cmd_sect_add) begin
                    sel_n   = sel | add_bit;
                    restart = 1'b1;
                end else if (exp_win) begin
                    ctl_n.step = STEP_PRE;
                    if (eff == '0) begin
                        ctl_n.st = ST_ALLPROT;
                        sel_n    = '0;
                        restart  = 1'b1;
                    end else begin
                        ctl_n.st = ST_RUN;
                        sel_n    = eff;
                    end
                end
            end
            ST_SUSP_WIN: begin
                if (cmd_resume) begin
                    ctl_n.step = STEP_PRE;
                    if (eff == '0) begin
                        ctl_n.st = ST_ALLPROT;
                        sel_n    = '0;
                        restart  = 1'b1;
                    end else begin
                        ctl_n.st = ST_RUN;
                        sel_n    = eff;
                    end
                end
            end
            ST_RUN: begin
                if (!pick_valid) begin
                    ctl_n = CTL_RESET;
                end else if (eng_done) begin
                    if (ctl.step == STEP_PRE) begin
                        ctl_n.step = STEP_ERASE;
                    end else begin
                        ctl_n.step = STEP_PRE;
                        sel_n      = sel & ~cur_bit;
                    end
                    if (ctl.step == STEP_ERASE && (sel & ~cur_bit) == '0) begin
                        ctl_n = CTL_RESET;
                    end else if (ctl.pend) begin
                        ctl_n.st   = ST_SUSP_RUN;
                        ctl_n.pend = 1'b0;
                    end
                end else if (ctl.pend && exp_sus) begin
                    ctl_n.st   = ST_SUSP_RUN;
                    ctl_n.pend = 1'b0;
                end else if (cmd_suspend && !ctl.chip && !ctl.pend) begin
                    ctl_n.pend = 1'b1;
                    restart    = 1'b1;
                end
            end
            ST_SUSP_RUN: begin
                if (cmd_resume) ctl_n.st = ST_RUN;
            end
            ST_ALLPROT: begin
                if (exp_all) ctl_n = CTL_RESET;
            end
            default: ctl_n = CTL_RESET;
        endcase
        if (hw_reset) begin
            ctl_n = CTL_RESET;
            sel_n = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl <= CTL_RESET;
            sel <= '0;
        end else begin
            ctl <= ctl_n;
            sel <= sel_n;
        end
    end

    assign eng_pre_req = (ctl.st == ST_RUN) && pick_valid && (ctl.step == STEP_PRE);
    assign eng_ers_req = (ctl.st == ST_RUN) && pick_valid && (ctl.step == STEP_ERASE);
    assign eng_sect    = pick_idx;
    assign window_open = (ctl.st == ST_WINDOW);
    assign erasing     = (ctl.st == ST_RUN) || (ctl.st == ST_ALLPROT);
    assign busy        = window_open || erasing;
    assign suspended   = (ctl.st == ST_SUSP_WIN) || (ctl.st == ST_SUSP_RUN);

endmodule

// File: rtl/sector_erase_sched_chk.sv
module sector_erase_sched_chk #(
    parameter int IW = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          hw_reset,
    input logic          cmd_sect_add,
    input logic          cmd_chip_erase,
    input logic          cmd_resume,
    input logic          eng_done,
    input logic          eng_pre_req,
    input logic          eng_ers_req,
    input logic [IW-1:0] eng_sect,
    input logic          busy,
    input logic          window_open,
    input logic          erasing,
    input logic          suspended
);
    // R1: the status phases never overlap
    p_flags_excl_r1: assert property (@(posedge clk) disable iff (rst)
        $onehot0({window_open, erasing, suspended}));

    // R5: one request kind at a time
    p_req_excl_r5: assert property (@(posedge clk) disable iff (rst)
        $onehot0({eng_pre_req, eng_ers_req}));

    // R5: erase step of a sector only after its preprogram step completed
    p_pre_then_erase_r5: assert property (@(posedge clk) disable iff (rst)
        (eng_pre_req && !eng_done) |=> !eng_ers_req);

    // R5: sector under work holds until its step completes
    p_sect_stable_r5: assert property (@(posedge clk) disable iff (rst)
        (eng_pre_req && !eng_done) |=> (!eng_pre_req || $stable(eng_sect)));

    // R2: no engine activity while the window runs
    p_window_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        window_open |-> (!eng_pre_req && !eng_ers_req));

    // R8: no requests while suspended, and suspension persists until resume
    p_susp_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        suspended |-> (!eng_pre_req && !eng_ers_req));
    p_susp_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (suspended && !cmd_resume && !hw_reset) |=> suspended);

    // R10: resume in idle leaves the block idle
    p_resume_idle_r10: assert property (@(posedge clk) disable iff (rst)
        (!busy && !suspended && cmd_resume && !cmd_sect_add && !cmd_chip_erase && !hw_reset)
        |=> (!busy && !suspended));

    // R11: hardware reset aborts everything
    p_hwrst_r11: assert property (@(posedge clk) disable iff (rst)
        hw_reset |=> (!busy && !suspended && !eng_pre_req && !eng_ers_req));
endmodule

bind sector_erase_sched sector_erase_sched_chk #(.IW(IW)) chk_i (
    .clk(clk), .rst(rst), .hw_reset(hw_reset), .cmd_sect_add(cmd_sect_add),
    .cmd_chip_erase(cmd_chip_erase), .cmd_resume(cmd_resume), .eng_done(eng_done),
    .eng_pre_req(eng_pre_req), .eng_ers_req(eng_ers_req), .eng_sect(eng_sect),
    .busy(busy), .window_open(window_open), .erasing(erasing), .suspended(suspended)
);

// File: tb/sector_erase_sched_tb_top.sv
module sector_erase_sched_tb_top;
    localparam int NS = 11;
    localparam int IW = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic hw_reset = 0, cmd_sect_add = 0, cmd_chip_erase = 0, cmd_suspend = 0;
    logic cmd_resume = 0, cmd_other = 0, us_tick = 0, eng_done = 0;
    logic [IW-1:0] sect_idx = '0;
    logic [NS-1:0] prot_mask = '0;
    logic eng_pre_req, eng_ers_req, busy, window_open, erasing, suspended;
    logic [IW-1:0] eng_sect;

    int n_chk = 0;
    int n_bad = 0;
    int eng_dly = 3;
    int eng_cnt = 0;
    bit finished = 0;
    logic [IW:0] exp_q[$];

    always #5 clk = ~clk;

    sector_erase_sched dut_i (
        .clk(clk), .rst(rst), .hw_reset(hw_reset), .cmd_sect_add(cmd_sect_add),
        .cmd_chip_erase(cmd_chip_erase), .cmd_suspend(cmd_suspend), .cmd_resume(cmd_resume),
        .cmd_other(cmd_other), .sect_idx(sect_idx), .prot_mask(prot_mask), .us_tick(us_tick),
        .eng_done(eng_done), .eng_pre_req(eng_pre_req), .eng_ers_req(eng_ers_req),
        .eng_sect(eng_sect), .busy(busy), .window_open(window_open), .erasing(erasing),
        .suspended(suspended)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // engine model and scoreboard monitor
    always @(negedge clk) begin
        if (eng_pre_req || eng_ers_req) begin
            if (eng_cnt >= eng_dly) begin
                n_chk++;
                if (exp_q.size() == 0) begin
                    n_bad++;
                    $display("FAIL R5/R6: actual step %0d:%0d expected none", eng_ers_req, eng_sect);
                end else begin
                    logic [IW:0] e;
                    e = exp_q.pop_front();
                    if (e != {eng_ers_req, eng_sect}) begin
                        n_bad++;
                        $display("FAIL R5: actual step %0d:%0d expected %0d:%0d",
                                 eng_ers_req, eng_sect, e[IW], e[IW-1:0]);
                    end
                end
                eng_done = 1'b1;
                eng_cnt  = 0;
            end else begin
                eng_done = 1'b0;
                eng_cnt++;
            end
        end else begin
            eng_done = 1'b0;
            eng_cnt  = 0;
        end
    end

    task automatic push_sect(input int s);
        exp_q.push_back({1'b0, IW'(s)});
        exp_q.push_back({1'b1, IW'(s)});
    endtask

    task automatic add(input int s);
        sect_idx = IW'(s); cmd_sect_add = 1; @(negedge clk); cmd_sect_add = 0;
    endtask
    task automatic p_susp();  cmd_suspend = 1; @(negedge clk); cmd_suspend = 0; endtask
    task automatic p_res();   cmd_resume = 1;  @(negedge clk); cmd_resume = 0;  endtask
    task automatic p_other(); cmd_other = 1;   @(negedge clk); cmd_other = 0;   endtask
    task automatic p_chip();  cmd_chip_erase = 1; @(negedge clk); cmd_chip_erase = 0; endtask
    task automatic p_hw();    hw_reset = 1;    @(negedge clk); hw_reset = 0;    endtask
    task automatic ticks(input int n);
        us_tick = 1; repeat (n) @(negedge clk); us_tick = 0;
    endtask
    task automatic wait_idle();
        for (int i = 0; i < 5000; i++) begin
            if (!busy && !suspended) break;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1
        chk("R1 busy", busy, 0);
        chk("R1 flags", {window_open, erasing, suspended}, 0);
        chk("R1 reqs", {eng_pre_req, eng_ers_req}, 0);

        // R2 window, restart; R5 order; R10 ignored commands
        add(5);
        chk("R2 open", window_open, 1);
        chk("R2 busy", busy, 1);
        ticks(49);
        chk("R2 still open", window_open, 1);
        add(2);
        ticks(49);
        chk("R2 restarted", window_open, 1);
        push_sect(2); push_sect(5);
        ticks(1);
        chk("R2 closed", window_open, 0);
        chk("R2 erasing", erasing, 1);
        add(4);
        p_other();
        chk("R10 still erasing", erasing, 1);
        wait_idle();
        chk("R5 all steps seen", exp_q.size(), 0);
        chk("R5 idle", busy, 0);

        // R6 protected skipped
        prot_mask = 11'h008;
        push_sect(0); push_sect(7);
        add(3); add(7); add(0);
        ticks(50);
        wait_idle();
        chk("R6 steps", exp_q.size(), 0);

        // R3 discard
        add(4);
        p_other();
        chk("R3 window closed", window_open, 0);
        chk("R3 idle", busy, 0);
        add(4);
        p_res();
        chk("R3 resume discards", busy, 0);
        ticks(60);
        chk("R3 no erase", erasing, 0);

        // R7 all protected
        prot_mask = 11'h040;
        add(6);
        ticks(50);
        chk("R7 erasing", erasing, 1);
        ticks(99);
        chk("R7 still busy", busy, 1);
        ticks(1);
        chk("R7 done", busy, 0);
        prot_mask = '0;

        // R4 suspend in window
        add(1);
        ticks(10);
        p_susp();
        chk("R4 suspended", suspended, 1);
        chk("R4 window closed", window_open, 0);
        chk("R4 not busy", busy, 0);
        ticks(100);
        chk("R4 held", suspended, 1);
        push_sect(1);
        p_res();
        chk("R4 resume erasing", erasing, 1);
        wait_idle();
        chk("R4 steps", exp_q.size(), 0);

        // R8 suspend at step boundary
        eng_dly = 5;
        push_sect(8); push_sect(9);
        add(8); add(9);
        ticks(50);
        p_susp();
        chk("R8 pending", suspended, 0);
        repeat (10) @(negedge clk);
        chk("R8 suspended at boundary", suspended, 1);
        chk("R8 quiet", {eng_pre_req, eng_ers_req}, 0);
        chk("R8 one step done", exp_q.size(), 3);
        p_res();
        chk("R8 resumed", erasing, 1);
        wait_idle();
        chk("R8 steps", exp_q.size(), 0);

        // R8 suspend by timeout
        eng_dly = 1000;
        add(10);
        ticks(50);
        p_susp();
        ticks(SUSP_TICKS - 1);
        chk("R8 before timeout", suspended, 0);
        ticks(1);
        chk("R8 at timeout", suspended, 1);
        eng_dly = 3;
        push_sect(10);
        p_res();
        wait_idle();
        chk("R8 repeated step", exp_q.size(), 0);

        // R9 chip erase
        eng_dly = 2;
        prot_mask = 11'h401;
        for (int s = 1; s <= 9; s++) push_sect(s);
        p_chip();
        chk("R9 erasing at once", erasing, 1);
        chk("R9 no window", window_open, 0);
        p_susp();
        repeat (3) @(negedge clk);
        chk("R9 suspend ignored", suspended, 0);
        wait_idle();
        chk("R9 steps", exp_q.size(), 0);
        prot_mask = '0;

        // R10 resume in idle
        p_res();
        chk("R10 idle resume", {busy, suspended}, 0);

        // R11 hardware reset
        eng_dly = 1000;
        add(3);
        ticks(50);
        repeat (2) @(negedge clk);
        p_hw();
        chk("R11 idle", busy, 0);
        chk("R11 reqs dropped", {eng_pre_req, eng_ers_req}, 0);
        ticks(60);
        chk("R11 stays idle", {busy, suspended}, 0);
        chk("R11 queue", exp_q.size(), 0);

        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    localparam int SUSP_TICKS = 20;

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule